// File: doc/BRIEF.md
# Multi-Channel 100 Mbps Transmit Nibble Encoder

This block is the PHY-side transmit path of a 100 Mbps media-independent interface. A group of channels share one free-running transmit clock. Each channel has its own enable, error flag and 4-bit data input. On every rising edge a channel samples its inputs. While a packet is in progress, it turns the nibble into a 5-bit code group through 4B/5B encoding.

Each packet is framed by delimiters. The first two nibbles accepted in a packet are replaced by the start pair J and K. The fall of the enable is followed by the end pair T and R. Between packets the channel sends idle code groups. An error flag sampled with a data nibble replaces that one nibble with the halt code group. The code-group stream is meant for a downstream serializer and line coder, which are not part of this block.

Top module: `mii_tx_encoder`

## Requirements
- R1: While reset is high, every channel outputs the idle code 11111 with its valid strobe low. The strobe is high from the first rising edge at which reset is sampled low.
- R2: The code group sampled at an edge appears on the channel's output right after that edge: one register, no further delay. Code bit 4 is the first bit on the line.
- R3: While the channel is idle and its enable is sampled low, the output is idle (11111), whatever the data and error inputs carry.
- R4: The first edge at which the enable is sampled high outputs J (11000), and the second outputs K (10001). The two nibbles sampled at those edges are discarded, and so are any error flags sampled with them.
- R5: From the third high edge on, each nibble is encoded as 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R6: A data nibble sampled with its error flag high is output as the halt code 00100. This affects only that one nibble.
- R7: The first low enable after a packet outputs T (01101). The next edge outputs R (00111), and the edges after that output idle.
- R8: The edge that outputs R ignores the enable. A packet that restarts right after T begins with J one edge later.
- R9: A packet of a single nibble outputs J, then T, then R.
- R10: Channels are independent. Activity on one channel never changes the code stream of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared continuous transmit clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset, all channels |
| tx_en | input | NUM_CH | Per-channel transmit enable |
| tx_er | input | NUM_CH | Per-channel transmit error flag |
| txd | input | 4*NUM_CH | Per-channel data nibble, channel c at bits 4c+3:4c |
| cg_out | output | 5*NUM_CH | Per-channel code group, channel c at bits 5c+4:5c |
| cg_valid | output | NUM_CH | Per-channel code-group valid strobe |

## Verification
The assertions take two things for granted. First, reset is held for at least one rising edge before the first packet. Second, the enable, error and data inputs settle well away from the rising edge, so each edge sees one clean sample. The stimulus changes every input 2 ns after a rising edge and checks the outputs at that same moment. Gaps between packets of one and of several low cycles are both applied, so the path from R into a restarted packet is covered.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;
  localparam int NIB_W = 4;
  localparam int CG_W  = 5;

  typedef logic [CG_W-1:0]  cg_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam cg_t CG_IDLE = 5'b11111;
  localparam cg_t CG_J    = 5'b11000;
  localparam cg_t CG_K    = 5'b10001;
  localparam cg_t CG_T    = 5'b01101;
  localparam cg_t CG_R    = 5'b00111;
  localparam cg_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {
    LS_IDLE,   // between packets
    LS_SSD2,   // J sent, next accepted nibble becomes K
    LS_DATA,   // data phase
    LS_TAIL    // T sent, R follows unconditionally
  } lane_st_e;

  function automatic cg_t enc_4b5b(input nib_t n);
    cg_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mii_tx_symmap.sv
module mii_tx_symmap
  import mii_tx_pkg::*;
(
  input  nib_t nib,
  input  logic err,
  output cg_t  sym
);
  always_comb begin
    if (err) sym = CG_H;     // R6
    else     sym = enc_4b5b(nib);  // R5
  end
endmodule

// File: rtl/mii_tx_lane.sv
module mii_tx_lane
  import mii_tx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic er,
  input  nib_t nib,
  output cg_t  cg,
  output logic cg_vld
);
  lane_st_e st_q, st_d;
  cg_t      cg_d;
  cg_t      data_sym;

  // named events for the checks
  logic ev_start, ev_data, ev_end, ev_quiet;
  assign ev_start = (st_q == LS_IDLE) && en;
  assign ev_data  = (st_q == LS_DATA) && en;
  assign ev_end   = ((st_q == LS_DATA) || (st_q == LS_SSD2)) && !en;
  assign ev_quiet = (st_q == LS_IDLE) && !en;

  mii_tx_symmap u_map (
    .nib (nib),
    .err (er),
    .sym (data_sym)
  );

  always_comb begin
    st_d = st_q;
    cg_d = CG_IDLE;
    unique case (st_q)
      LS_IDLE: begin
        if (en) begin
          cg_d = CG_J;
          st_d = LS_SSD2;
        end
      end
      LS_SSD2: begin
        if (en) begin
          cg_d = CG_K;
          st_d = LS_DATA;
        end else begin
          cg_d = CG_T;
          st_d = LS_TAIL;
        end
      end
      LS_DATA: begin
        if (en) begin
          cg_d = data_sym;
        end else begin
          cg_d = CG_T;
          st_d = LS_TAIL;
        end
      end
      LS_TAIL: begin
        cg_d = CG_R;
        st_d = LS_IDLE;
      end
      default: begin
        cg_d = CG_IDLE;
        st_d = LS_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= LS_IDLE;
      cg     <= CG_IDLE;
      cg_vld <= 1'b0;
    end else begin
      st_q   <= st_d;
      cg     <= cg_d;
      cg_vld <= 1'b1;
    end
  end

  AST_VALID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> cg_vld); // R1
  AST_QUIET_IS_IDLE: assert property (@(posedge clk) disable iff (rst) ev_quiet |=> (cg == CG_IDLE)); // R3
  AST_START_IS_J: assert property (@(posedge clk) disable iff (rst) ev_start |=> (cg == CG_J)); // R4
  AST_J_THEN_K_OR_T: assert property (@(posedge clk) disable iff (rst) (cg == CG_J) |=> (cg == CG_K || cg == CG_T)); // R9
  AST_ERR_IS_HALT: assert property (@(posedge clk) disable iff (rst) (ev_data && er) |=> (cg == CG_H)); // R6
  AST_DATA_NOT_CTRL: assert property (@(posedge clk) disable iff (rst) (ev_data && !er) |=> (cg != CG_H && cg != CG_IDLE)); // R5
  AST_END_IS_T: assert property (@(posedge clk) disable iff (rst) ev_end |=> (cg == CG_T)); // R7
  AST_T_THEN_R: assert property (@(posedge clk) disable iff (rst) (cg == CG_T) |=> (cg == CG_R)); // R8
endmodule

// File: rtl/mii_tx_encoder.sv
module mii_tx_encoder
  import mii_tx_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CH-1:0]      tx_en,
  input  logic [NUM_CH-1:0]      tx_er,
  input  logic [NUM_CH*NIB_W-1:0] txd,
  output logic [NUM_CH*CG_W-1:0]  cg_out,
  output logic [NUM_CH-1:0]      cg_valid
);
  localparam int DIN_W  = NUM_CH * NIB_W;
  localparam int DOUT_W = NUM_CH * CG_W;

  logic [DIN_W-1:0]  din_w;
  logic [DOUT_W-1:0] dout_w;
  assign din_w  = txd;
  assign cg_out = dout_w;

  // R10: one independent lane per channel, clock and reset shared
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    mii_tx_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .en     (tx_en[c]),
      .er     (tx_er[c]),
      .nib    (din_w[c*NIB_W +: NIB_W]),
      .cg     (dout_w[c*CG_W +: CG_W]),
      .cg_vld (cg_valid[c])
    );
  end
endmodule

// File: tb/sim_mii_tx_encoder.sv
module sim_mii_tx_encoder;
  localparam int NCH = 4;
  localparam logic [79:0] TBL = {5'b11101, 5'b11100, 5'b11011, 5'b11010,
                                 5'b10111, 5'b10110, 5'b10011, 5'b10010,
                                 5'b01111, 5'b01110, 5'b01011, 5'b01010,
                                 5'b10101, 5'b10100, 5'b01001, 5'b11110};
  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001,
                         T_ = 5'b01101, R_ = 5'b00111, H_ = 5'b00100;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0]   en, er;
  logic [NCH*4-1:0] d;
  logic [NCH*5-1:0] cg;
  logic [NCH-1:0]   vld;
  int checks = 0;
  int fails  = 0;

  mii_tx_encoder #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst(rst), .tx_en(en), .tx_er(er), .txd(d),
    .cg_out(cg), .cg_valid(vld)
  );

  always #10 clk = ~clk;

  function automatic logic [4:0] exp_code(input logic [3:0] n);
    return TBL[n*5 +: 5];
  endfunction

  function automatic logic [4:0] lane_cg(input int c);
    return cg[c*5 +: 5];
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic drive0(input logic e, input logic r, input logic [3:0] n);
    en[0] = e; er[0] = r; d[3:0] = n;
  endtask

  task automatic t_reset;
    rst = 1'b1; en = '0; er = '0; d = '0;
    tick; tick;
    for (int c = 0; c < NCH; c++) begin
      chk("R1 reset code", lane_cg(c), I_);
      chk("R1 reset valid", {4'b0, vld[c]}, 5'd0);
    end
    rst = 1'b0;
    tick;
    chk("R1 valid after reset", {1'b0, vld}, 5'b01111);
  endtask

  task automatic t_quiet;
    en = '0; er = '1; d = 16'hA5C3;
    for (int i = 0; i < 3; i++) begin
      tick;
      for (int c = 0; c < NCH; c++) chk("R3 idle ignores data/err", lane_cg(c), I_);
      d = ~d;
    end
    er = '0;
  endtask

  task automatic t_full_table;
    drive0(1, 1, 4'h5); tick; chk("R4 J first", lane_cg(0), J_);
    drive0(1, 0, 4'h5); tick; chk("R4 K second", lane_cg(0), K_);
    for (int n = 0; n < 16; n++) begin
      drive0(1, 0, 4'(n)); tick;
      chk("R5 data encoding / R2 latency", lane_cg(0), exp_code(4'(n)));
    end
    drive0(0, 1, 4'h7); tick; chk("R7 T on end", lane_cg(0), T_);
    drive0(0, 0, 4'h0); tick; chk("R7 R after T", lane_cg(0), R_);
    tick; chk("R7 idle after R", lane_cg(0), I_);
  endtask

  task automatic t_error;
    drive0(1, 0, 4'h5); tick;
    drive0(1, 0, 4'hD); tick;
    drive0(1, 0, 4'h3); tick; chk("R5 before error", lane_cg(0), exp_code(4'h3));
    drive0(1, 1, 4'h3); tick; chk("R6 halt", lane_cg(0), H_);
    drive0(1, 0, 4'h3); tick; chk("R6 single nibble only", lane_cg(0), exp_code(4'h3));
    drive0(0, 0, 4'h0); tick; chk("R7 T after error packet", lane_cg(0), T_);
    tick; tick;
  endtask

  task automatic t_short_and_restart;
    drive0(1, 0, 4'h5); tick; chk("R9 J", lane_cg(0), J_);
    drive0(0, 0, 4'h0); tick; chk("R9 T after one nibble", lane_cg(0), T_);
    drive0(1, 0, 4'h9); tick; chk("R8 R despite enable", lane_cg(0), R_);
    tick; chk("R8 restart J", lane_cg(0), J_);
    tick; chk("R8 restart K", lane_cg(0), K_);
    tick; chk("R8 restart data", lane_cg(0), exp_code(4'h9));
    drive0(0, 0, 4'h0); tick; chk("R7 T", lane_cg(0), T_);
    tick; chk("R7 R", lane_cg(0), R_);
    tick;
  endtask

  task automatic t_parallel;
    logic [4:0] e;
    for (int cy = 0; cy < 12; cy++) begin
      for (int c = 0; c < NCH; c++) begin
        en[c] = (cy >= c) && (cy <= c + 4);
        er[c] = 1'b0;
        d[c*4 +: 4] = 4'(c + cy);
      end
      tick;
      for (int c = 0; c < NCH; c++) begin
        int rel = cy - c;
        if (rel < 0 || rel > 6) e = I_;
        else if (rel == 0) e = J_;
        else if (rel == 1) e = K_;
        else if (rel <= 4) e = exp_code(4'(c + cy));
        else if (rel == 5) e = T_;
        else e = R_;
        chk("R10 independent channels", lane_cg(c), e);
      end
    end
    en = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset;
    t_quiet;
    t_full_table;
    t_error;
    t_short_and_restart;
    t_parallel;
    tick;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule